// File: doc/BRIEF.md
# Shared Timer Clock-Enable Generator with Synchronised Start

This block produces the count-enable pulses for three timer/counters from one system clock. A free-running 10-bit divider counter is shared by all three timers. Each timer has its own 3-bit source select. The select picks one of these sources: no counting, every cycle, one of four divided rates, or a rising or falling edge on that timer's external clock pin. External pins pass through a two-stage synchroniser and an edge detector, and they never go through the divider.

A small control register holds three bits: a hold (synchronised-start) bit, a reset bit for the shared divider, and a reset bit for a separate auxiliary divider, which is brought out as a level. A reset bit written to one normally lasts a single cycle. While hold is set, the reset bits stay asserted and every timer enable is blocked. Software can therefore configure all timers while nothing advances, then clear hold. All timers restart from the same divider phase in the same cycle.

Top module: `tpre_clk_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the control register clears to zero. After reset, `ctl_rdata` reads 0, `aux_rst` is 0, and `cnt_en` is 0 for select 000.
- R2: A timer whose select is 000 never gets an enable. With select 001, its enable is high in every cycle in which the shared reset bit is clear.
- R3: Selects 010, 011, 100 and 101 divide by 8, 64, 256 and 1024. Number the cycles after the shared reset bit clears n = 0, 1, 2, ... A divided enable is high exactly in the cycles where n mod N = N-1.
- R4: Writing 1 to the shared reset bit (bit 0) with hold (bit 2) at 0 makes the bit read 1 for one cycle. Hardware then clears it, and the divider restarts from zero.
- R5: While hold is 1, a written reset bit stays at 1 and all three `cnt_en` bits stay 0.
- R6: Writing hold to 0 clears both reset bits at the same edge. All timers then follow the R3 schedule from n = 0 together.
- R7: The auxiliary reset bit (bit 1) obeys the same one-cycle and hold rules and drives `aux_rst`. It does not disturb the shared divider's phase.
- R8: With select 111, a rising edge on the timer's pin gives exactly one `cnt_en` pulse. The pulse appears three cycles after the cycle in which the pin was driven high.
- R9: With select 110, a falling edge gives exactly one pulse, with the same three-cycle latency.
- R10: External edges are never divided. Every edge counts, including edges whose half periods are only two cycles long.
- R11: `ctl_rdata` returns hold at bit 2, the auxiliary reset at bit 1 and the shared reset at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Write data: bit 2 hold, bit 1 aux reset, bit 0 shared reset |
| ctl_rdata | output | 3 | Current control register value |
| clk_sel | input | 3*NUM_TMR | Per-timer source select, timer i at bits [3i+2:3i] |
| ext_pin | input | NUM_TMR | Asynchronous external clock pins |
| cnt_en | output | NUM_TMR | Single-cycle count enables, one per timer |
| aux_rst | output | 1 | Auxiliary divider reset level |

## Verification
Control register effects show on `ctl_rdata` and `cnt_en` one cycle after the write edge. A single reset pulse takes a second edge to clear, so the divided schedule starts one sample after the pulse is seen. A hold release starts it at the very sample following the release write. External pulses arrive three samples after the sample in which the pin was driven. The bench drives every input on the falling edge and samples on the falling edge. It indexes every expectation by the number of falling edges since the relevant stimulus. It compares all three enables in every cycle of sweeps longer than two full divider periods.

// File: rtl/tpre_pkg.sv
`timescale 1ns/1ps
// Package: shared types and constants for the timer clock-enable generator.
// Assumes three-bit source selects and four divider taps.
package tpre_pkg;

    // Per-timer count source encoding
    typedef enum logic [2:0] {
        SRC_OFF      = 3'b000,
        SRC_CLK      = 3'b001,
        SRC_D8       = 3'b010,
        SRC_D64      = 3'b011,
        SRC_D256     = 3'b100,
        SRC_D1024    = 3'b101,
        SRC_EXT_FALL = 3'b110,
        SRC_EXT_RISE = 3'b111
    } src_sel_e;

    localparam int SEL_W    = 3;
    localparam int NUM_TAPS = 4;

    // Control register layout
    localparam int CTL_W    = 3;
    localparam int CB_MAIN  = 0;
    localparam int CB_AUX   = 1;
    localparam int CB_HOLD  = 2;

    // log2 of the division ratio for tap index idx
    function automatic int tap_log2(input int idx);
        case (idx)
            0:       return 3;
            1:       return 6;
            2:       return 8;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/tpre_ctrl.sv
`timescale 1ns/1ps
// Module: tpre_ctrl
// Holds the hold bit and the two divider reset bits. Reset bits last a
// single cycle unless hold is set; writing hold to zero drops them at once.
// Assumes writes are single-cycle strobes in the clk domain.
module tpre_ctrl
    import tpre_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output logic             hold_o,
    output logic             main_rst_o,
    output logic             aux_rst_o,
    output logic [CTL_W-1:0] rdata
);

    logic hold_q;
    logic main_q;
    logic aux_q;

    // Register update: write sets, hold keeps, otherwise self-clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            main_q <= 1'b0;
            aux_q  <= 1'b0;
        end else if (we) begin
            hold_q <= wdata[CB_HOLD];
            main_q <= wdata[CB_MAIN] | (main_q & wdata[CB_HOLD]);
            aux_q  <= wdata[CB_AUX]  | (aux_q  & wdata[CB_HOLD]);
        end else if (!hold_q) begin
            main_q <= 1'b0;
            aux_q  <= 1'b0;
        end
    end

    // Read-back assembly
    always_comb begin
        rdata          = '0;
        rdata[CB_HOLD] = hold_q;
        rdata[CB_AUX]  = aux_q;
        rdata[CB_MAIN] = main_q;
    end

    assign hold_o     = hold_q;
    assign main_rst_o = main_q;
    assign aux_rst_o  = aux_q;

endmodule

// File: rtl/tpre_divider.sv
`timescale 1ns/1ps
// Module: tpre_divider
// Free-running shared divider counter. Each tap pulses for one cycle when
// its low bits are all ones, i.e. on the cycle before they roll to zero.
// Assumes PRE_W is at least the widest tap.
module tpre_divider
    import tpre_pkg::*;
#(
    parameter int PRE_W = 10
)(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    output logic [NUM_TAPS-1:0] taps_o
);

    logic [PRE_W-1:0] cnt_q;

    // Counter: cleared by reset or divider reset, else increments
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Tap decode per division ratio
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        localparam int TW = tap_log2(g);
        assign taps_o[g] = &cnt_q[TW-1:0];
    end

endmodule

// File: rtl/tpre_pin_sync.sv
`timescale 1ns/1ps
// Module: tpre_pin_sync
// Brings an asynchronous pin into the clk domain through SYNC_STAGES flops,
// then registers single-cycle rise and fall pulses.
// Assumes each pin half period exceeds one clk cycle.
module tpre_pin_sync #(
    parameter int SYNC_STAGES = 2
)(
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise_o,
    output logic fall_o
);

    logic [SYNC_STAGES:0] chain_q;
    logic                 rise_q;
    logic                 fall_q;

    // Synchroniser chain plus one history stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[SYNC_STAGES-1:0], pin};
        end
    end

    // Edge pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_q <= 1'b0;
            fall_q <= 1'b0;
        end else begin
            rise_q <= chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
            fall_q <= ~chain_q[SYNC_STAGES-1] & chain_q[SYNC_STAGES];
        end
    end

    assign rise_o = rise_q;
    assign fall_o = fall_q;

endmodule

// File: rtl/tpre_src_mux.sv
`timescale 1ns/1ps
// Module: tpre_src_mux
// Picks one timer's count enable from the select code; halt blocks all.
// Assumes all inputs are already synchronous to clk.
module tpre_src_mux
    import tpre_pkg::*;
(
    input  logic [SEL_W-1:0]    sel,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic                rise,
    input  logic                fall,
    input  logic                halt,
    output logic                en_o
);

    logic raw;

    // Source decode
    always_comb begin
        raw = 1'b0;
        case (src_sel_e'(sel))
            SRC_OFF:      raw = 1'b0;
            SRC_CLK:      raw = 1'b1;
            SRC_D8:       raw = taps[0];
            SRC_D64:      raw = taps[1];
            SRC_D256:     raw = taps[2];
            SRC_D1024:    raw = taps[3];
            SRC_EXT_FALL: raw = fall;
            SRC_EXT_RISE: raw = rise;
            default:      raw = 1'b0;
        endcase
    end

    assign en_o = raw & ~halt;

endmodule

// File: rtl/tpre_clk_gen.sv
`timescale 1ns/1ps
// Module: tpre_clk_gen (top)
// Count-enable generator for NUM_TMR timers sharing one divider, with a
// hold bit that halts all timers and releases them together.
// Assumes ext_pin signals are slower than clk/2.5.
module tpre_clk_gen
    import tpre_pkg::*;
#(
    parameter int NUM_TMR     = 3,
    parameter int PRE_W       = 10,
    parameter int SYNC_STAGES = 2
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctl_we,
    input  logic [CTL_W-1:0]         ctl_wdata,
    output logic [CTL_W-1:0]         ctl_rdata,
    input  logic [NUM_TMR*SEL_W-1:0] clk_sel,
    input  logic [NUM_TMR-1:0]       ext_pin,
    output logic [NUM_TMR-1:0]       cnt_en,
    output logic                     aux_rst
);

    logic                hold;
    logic                main_rst;
    logic [NUM_TAPS-1:0] taps;

    tpre_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (ctl_we),
        .wdata      (ctl_wdata),
        .hold_o     (hold),
        .main_rst_o (main_rst),
        .aux_rst_o  (aux_rst),
        .rdata      (ctl_rdata)
    );

    tpre_divider #(.PRE_W(PRE_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (main_rst),
        .taps_o (taps)
    );

    // One synchroniser and one selector per timer
    for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
        logic rise;
        logic fall;

        tpre_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (ext_pin[t]),
            .rise_o (rise),
            .fall_o (fall)
        );

        tpre_src_mux u_mux (
            .sel  (clk_sel[t*SEL_W +: SEL_W]),
            .taps (taps),
            .rise (rise),
            .fall (fall),
            .halt (main_rst),
            .en_o (cnt_en[t])
        );
    end

    // Hold alone never blocks; it only keeps reset bits set
    logic unused_hold;
    assign unused_hold = hold;

endmodule

// File: rtl/tpre_chk.sv
`timescale 1ns/1ps
// Module: tpre_chk
// Property checker bound to tpre_clk_gen; observes ports only.
module tpre_chk
    import tpre_pkg::*;
#(
    parameter int NUM_TMR = 3
)(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     ctl_we,
    input logic [CTL_W-1:0]         ctl_wdata,
    input logic [CTL_W-1:0]         ctl_rdata,
    input logic [NUM_TMR*SEL_W-1:0] clk_sel,
    input logic [NUM_TMR-1:0]       cnt_en
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (ctl_rdata == '0)); // R1

    AST_MAIN_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[CB_MAIN] && !ctl_rdata[CB_HOLD] && !ctl_we) |=> !ctl_rdata[CB_MAIN]); // R4

    AST_HOLD_KEEPS_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_rdata[CB_MAIN] && ctl_rdata[CB_HOLD] && !ctl_we) |=> ctl_rdata[CB_MAIN]); // R5

    AST_HALT_NO_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[CB_MAIN] |-> (cnt_en == '0)); // R5

    AST_RELEASE_DROPS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata == '0) |=> (ctl_rdata == '0)); // R6

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
            (clk_sel[i*SEL_W +: SEL_W] == 3'b000) |-> !cnt_en[i]); // R2

        AST_CLK_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
            (clk_sel[i*SEL_W +: SEL_W] == 3'b001 && !ctl_rdata[CB_MAIN]) |-> cnt_en[i]); // R2

        AST_EXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            (clk_sel[i*SEL_W +: 2] == 2'b11 && clk_sel[i*SEL_W+2] && cnt_en[i])
            |=> !(clk_sel[i*SEL_W +: 2] == 2'b11 && clk_sel[i*SEL_W+2] && cnt_en[i])); // R8
    end

endmodule

bind tpre_clk_gen tpre_chk #(.NUM_TMR(NUM_TMR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_we    (ctl_we),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .clk_sel   (clk_sel),
    .cnt_en    (cnt_en)
);

// File: tb/sim_tpre_clk_gen.sv
`timescale 1ns/1ps
module sim_tpre_clk_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0;
    logic [2:0] ctl_wdata = '0;
    logic [2:0] ctl_rdata;
    logic [8:0] clk_sel = '0;
    logic [2:0] ext_pin = '0;
    logic [2:0] cnt_en;
    logic       aux_rst;

    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    tpre_clk_gen u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_we    (ctl_we),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .clk_sel   (clk_sel),
        .ext_pin   (ext_pin),
        .cnt_en    (cnt_en),
        .aux_rst   (aux_rst)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expected divided/plain enable, n cycles after the shared reset clears
    function automatic logic exp_en(input logic [2:0] sel, input int n);
        case (sel)
            3'b001:  return 1'b1;
            3'b010:  return (n % 8) == 7;
            3'b011:  return (n % 64) == 63;
            3'b100:  return (n % 256) == 255;
            3'b101:  return (n % 1024) == 1023;
            default: return 1'b0;
        endcase
    endfunction

    task automatic set_sel(input logic [2:0] s0, input logic [2:0] s1, input logic [2:0] s2);
        @(negedge clk);
        clk_sel = {s2, s1, s0};
    endtask

    // Write on one falling edge; return at the next falling edge
    task automatic wr(input logic [2:0] d);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    // Compare all enables for n = first..last; optional aux pulse write at n = aux_at
    task automatic sweep(input int first, input int last, input int aux_at);
        for (int s = first; s <= last; s++) begin
            @(negedge clk);
            for (int i = 0; i < 3; i++)
                chk("R3 divided/plain schedule", cnt_en[i], exp_en(clk_sel[i*3 +: 3], s));
            if (aux_at >= 0 && s == aux_at + 1) begin
                chk("R7 aux bit set", ctl_rdata[1], 1'b1);
                chk("R7 aux output", aux_rst, 1'b1);
            end
            if (aux_at >= 0 && s == aux_at + 2) begin
                chk("R7 aux self-clear", ctl_rdata, 3'b000);
                chk("R7 aux output low", aux_rst, 1'b0);
            end
            ctl_we = (s == aux_at);
            ctl_wdata = 3'b010;
        end
        ctl_we = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata after reset", ctl_rdata, 3'b000);
        chk("R1 enables after reset", cnt_en, 3'b000);
        chk("R1 aux after reset", aux_rst, 1'b0);

        // Config A: div8, div64, plain clock; single reset pulse
        set_sel(3'b010, 3'b011, 3'b001);
        wr(3'b001);
        chk("R4 reset bit reads 1", ctl_rdata, 3'b001);
        chk("R11 reset bit at position 0", ctl_rdata[0], 1'b1);
        chk("R2 plain clock blocked during reset", cnt_en, 3'b000);
        sweep(0, 2100, 100);

        // Config B: div256, div1024, off
        set_sel(3'b100, 3'b101, 3'b000);
        wr(3'b001);
        chk("R4 reset pulse B", ctl_rdata, 3'b001);
        sweep(0, 2100, -1);

        // Hold mode
        set_sel(3'b001, 3'b010, 3'b011);
        wr(3'b101);
        chk("R11 hold and reset bits", ctl_rdata, 3'b101);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            chk("R5 reset held", ctl_rdata, 3'b101);
            chk("R5 enables blocked", cnt_en, 3'b000);
        end
        wr(3'b111);
        chk("R11 all three bits", ctl_rdata, 3'b111);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            chk("R7 aux held", aux_rst, 1'b1);
            chk("R5 enables still blocked", cnt_en, 3'b000);
        end
        wr(3'b000);
        chk("R6 both reset bits released", ctl_rdata, 3'b000);
        chk("R6 aux released", aux_rst, 1'b0);
        for (int i = 0; i < 3; i++)
            chk("R6 aligned start n=0", cnt_en[i], exp_en(clk_sel[i*3 +: 3], 0));
        sweep(1, 200, -1);

        // External edges: timer0 rising, timer1 falling, timer2 off
        set_sel(3'b111, 3'b110, 3'b000);
        begin
            logic [7:0] hist = '0;
            logic [7:0] lf = 8'hA5;
            logic       pin = 1'b0;
            int         left = 6;
            int         n_rise = 0;
            int         n_fall = 0;
            int         got_rise = 0;
            int         got_fall = 0;
            for (int n = 0; n < 800; n++) begin
                @(negedge clk);
                chk("R8 rising edge pulse", cnt_en[0], hist[2] & ~hist[3]);
                chk("R9 falling edge pulse", cnt_en[1], ~hist[2] & hist[3]);
                chk("R2 off timer ignores pin", cnt_en[2], 1'b0);
                got_rise += int'(cnt_en[0]);
                got_fall += int'(cnt_en[1]);
                if (n < 780) begin
                    left--;
                    if (left == 0) begin
                        pin = ~pin;
                        if (pin) n_rise++; else n_fall++;
                        left = 2 + int'(lf[1:0]);
                        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
                    end
                end
                ext_pin = {pin, pin, pin};
                hist = {hist[6:0], pin};
            end
            chk("R10 every rising edge counted", got_rise, n_rise);
            chk("R10 every falling edge counted", got_fall, n_fall);
            chk("R10 edges present", (n_rise > 50) ? 1 : 0, 1);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        #(200000 * 20);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule